// File: doc/BRIEF.md
# Encoded Interrupt Priority Requester

This block sits between a set of peripheral interrupt lines and a processor that takes its interrupts as a 3-bit active-low priority code. Each of the seven request lines stands for one priority level, from 1 to 7. A rising edge on a line records that level as pending. The block presents the highest pending level on its output pins. Level 0, with all pins high, means nothing is requested, and level 7 is the top priority.

A presented level stays on the pins until the processor acknowledges it. The block recognises an acknowledge when the function code is all ones, the top four address bits are all ones and the address strobe is active. On the rising edge of that condition it clears the acknowledged request and presents the next highest one. A newer, higher request may raise the presented level at any time.

A reduced mode serves processors whose bit 0 and bit 2 pins are one shared wire. In that mode only levels 0, 2, 5 and 7 are presented, and any other pending level is rounded up to the next of these.

Top module: `irq_level_encoder`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, the output is 3'b111 (level 0) and no request is pending.
- R2: The output is the bitwise inverse of the presented level, with bit 0 the least significant bit. It comes from a register and reads 3'b111 exactly when nothing is pending.
- R3: A 0-to-1 transition of req_i[k] makes level k pending. The cycle after the clock edge that samples the new high value, the presented level is the highest pending level. A line held high does not raise a second request.
- R4: Without an acknowledge the presented level never decreases. A newly pending higher level raises it in the next cycle.
- R5: An acknowledge takes effect only on the first cycle of fc_i == 3'b111 with addr_hi_i == 4'hF and as_n_i == 0. It clears the presented level's pending request, and on the next cycle the output shows the highest remaining level. An acknowledge held for several cycles clears only one level.
- R6: An acknowledge attempt is ignored, and the presented level is kept, if any fc_i bit is 0, any addr_hi_i bit is 0, or as_n_i is 1.
- R7: With reduced_i high, the presented level is one of 0, 2, 5 or 7, so ipl_n_o[0] equals ipl_n_o[2]. The highest pending level is rounded up: 1 to 2, 3 and 4 to 5, 6 to 7.
- R8: In reduced mode an acknowledge clears every pending level that rounds to the presented level. For example, with levels 3 and 4 pending, presented as 5, one acknowledge clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Request lines; bit k (1..7) requests level k on its rising edge |
| reduced_i | input | 1 | Selects the tied-pin mode with levels 0, 2, 5, 7 only |
| fc_i | input | 3 | Processor function code |
| addr_hi_i | input | 4 | Processor address bits 19..16 |
| as_n_i | input | 1 | Processor address strobe, active low |
| ipl_n_o | output | 3 | Active-low encoded priority level to the processor |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that reduced_i changes only when it has been held for at least one cycle, because the rounding and stability checks are guarded by a stable mode. The bench changes inputs only on falling edges. It returns each request line and the acknowledge condition low for a full cycle between uses, so that every intended rising edge is seen. It switches the mode only while nothing is pending.

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
  parameter int LVLS = 7,
  parameter int FC_W = 3,
  parameter int AHI_W = 4,
  localparam int LW = $clog2(LVLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVLS:1]    req_i,
  input  logic             reduced_i,
  input  logic [FC_W-1:0]  fc_i,
  input  logic [AHI_W-1:0] addr_hi_i,
  input  logic             as_n_i,
  output logic [LW-1:0]    ipl_n_o
);

  logic [LVLS:1] req_q, pend, set, clr, pend_nxt;
  logic [LW-1:0] cur, tgt, cur_nxt;
  logic          ack_q;

  wire ack_now  = (&fc_i) & (&addr_hi_i) & ~as_n_i;
  wire ack_rise = ack_now & ~ack_q;

  function automatic logic [LW-1:0] round_lvl(input logic [LW-1:0] l, input logic red);
    logic [LW-1:0] r;
    r = l;
    if (red) begin
      case (l)
        LW'(1):        r = LW'(2);
        LW'(3), LW'(4): r = LW'(5);
        LW'(6):        r = LW'(7);
        default:       r = l;
      endcase
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] top_lvl(input logic [LVLS:1] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = 1; i <= LVLS; i++)
      if (v[i]) r = LW'(i);
    return r;
  endfunction

  assign set = req_i & ~req_q;

  for (genvar i = 1; i <= LVLS; i++) begin : g_clr
    assign clr[i] = ack_rise && (cur != '0) && (round_lvl(LW'(i), reduced_i) == cur);
  end

  assign pend_nxt = (pend & ~clr) | set;
  assign tgt      = round_lvl(top_lvl(pend_nxt), reduced_i);
  assign cur_nxt  = (ack_rise || tgt > cur) ? tgt : cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
      cur   <= '0;
      ack_q <= 1'b0;
    end else begin
      req_q <= req_i;
      pend  <= pend_nxt;
      cur   <= cur_nxt;
      ack_q <= ack_now;
    end
  end

  assign ipl_n_o = ~cur;

endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk #(
  parameter int LVLS = 7,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reduced_i,
  input logic [LW-1:0] ipl_n_o,
  input logic          ack_rise,
  input logic [LVLS:1] set,
  input logic [LVLS:1] pend
);

  wire [LW-1:0] lvl = ~ipl_n_o;

  p_idle_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) == (pend == '0));

  p_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rise |=> lvl >= $past(lvl));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rise && set == '0 && reduced_i == $past(reduced_i)) |=> $stable(ipl_n_o));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && lvl != '0 && set == '0) |=> $countones(pend) < $countones($past(pend)));

  p_reduced_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reduced_i && $past(reduced_i)) |-> (lvl == 0 || lvl == 2 || lvl == 5 || lvl == 7));

endmodule

bind irq_level_encoder irq_level_encoder_chk #(.LVLS(LVLS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reduced_i(reduced_i), .ipl_n_o(ipl_n_o),
  .ack_rise(ack_rise), .set(set), .pend(pend)
);

// File: tb/irq_level_encoder_test.sv
`timescale 1ns/1ps
module irq_level_encoder_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:1] req = '0;
  logic       red = 0;
  logic [2:0] fc = '0;
  logic [3:0] ahi = '0;
  logic       as_n = 1;
  logic [2:0] ipl_n;
  int checks = 0, failures = 0;
  bit done = 0;

  irq_level_encoder uut (.clk(clk), .rst_n(rst_n), .req_i(req), .reduced_i(red),
    .fc_i(fc), .addr_hi_i(ahi), .as_n_i(as_n), .ipl_n_o(ipl_n));

  always #4 clk = ~clk;

  // {req[7:1], reduced, ack, expected level}
  localparam logic [11:0] VEC [18] = '{
    {7'b0000100, 1'b0, 1'b0, 3'd3}, {7'b0000001, 1'b0, 1'b0, 3'd3},
    {7'b0100000, 1'b0, 1'b0, 3'd6}, {7'b0000000, 1'b0, 1'b1, 3'd3},
    {7'b0000000, 1'b0, 1'b1, 3'd1}, {7'b1000000, 1'b0, 1'b0, 3'd7},
    {7'b0000000, 1'b0, 1'b1, 3'd1}, {7'b0000000, 1'b0, 1'b1, 3'd0},
    {7'b0000001, 1'b1, 1'b0, 3'd2}, {7'b0000100, 1'b1, 1'b0, 3'd5},
    {7'b0001000, 1'b1, 1'b0, 3'd5}, {7'b0000000, 1'b1, 1'b1, 3'd2},
    {7'b0100000, 1'b1, 1'b0, 3'd7}, {7'b0000000, 1'b1, 1'b1, 3'd2},
    {7'b0000000, 1'b1, 1'b1, 3'd0}, {7'b0010010, 1'b1, 1'b0, 3'd5},
    {7'b0000000, 1'b1, 1'b1, 3'd2}, {7'b0000000, 1'b1, 1'b1, 3'd0}
  };

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // one-cycle stimulus, then check, then an idle cycle
  task automatic step(input logic [7:1] rq, input logic ack, input logic [2:0] f,
                      input logic [3:0] a, input logic s_n);
    @(negedge clk);
    req = rq;
    if (ack) begin fc = f; ahi = a; as_n = s_n; end
    @(negedge clk);
    req = '0; fc = '0; ahi = '0; as_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", ipl_n, 3'b111);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", ipl_n, 3'b111);

    foreach (VEC[i]) begin
      red = VEC[i][4];
      step(VEC[i][11:5], VEC[i][3], 3'b111, 4'hF, 1'b0);
      if (VEC[i][3]) chk(VEC[i][4] ? "R8 reduced ack" : "R5 ack", 3'(~ipl_n), VEC[i][2:0]);
      else if (VEC[i][4]) chk("R7 rounding", 3'(~ipl_n), VEC[i][2:0]);
      else chk("R3/R4 highest pending", 3'(~ipl_n), VEC[i][2:0]);
      if (VEC[i][4]) chk("R7 tied pins", ipl_n[0], ipl_n[2]);
      @(negedge clk);
    end

    red = 0;
    step(7'b0001010, 0, 3'b0, 4'h0, 1);
    chk("R3 two at once", 3'(~ipl_n), 4);
    step(7'b0001010, 0, 3'b0, 4'h0, 1);
    @(negedge clk);
    chk("R3 no re-request", 3'(~ipl_n), 4);
    step('0, 1, 3'b110, 4'hF, 0);
    chk("R6 fc bit low", 3'(~ipl_n), 4);
    step('0, 1, 3'b111, 4'hF, 1);
    chk("R6 strobe high", 3'(~ipl_n), 4);
    step('0, 1, 3'b111, 4'h7, 0);
    chk("R6 address bit low", 3'(~ipl_n), 4);

    @(negedge clk);
    fc = 3'b111; ahi = 4'hF; as_n = 0;
    repeat (3) @(negedge clk);
    fc = '0; ahi = '0; as_n = 1;
    chk("R5 held ack clears one", 3'(~ipl_n), 2);
    @(negedge clk);
    step('0, 1, 3'b111, 4'hF, 0);
    chk("R5 last ack", 3'(~ipl_n), 0);
    chk("R2 idle all ones", ipl_n, 3'b111);

    @(negedge clk);
    step(7'b0010000, 0, 3'b0, 4'h0, 1);
    chk("R2 inverse code", ipl_n, 3'b010);
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears", ipl_n, 3'b111);
    rst_n = 1;
    @(negedge clk);
    chk("R1 nothing pending after reset", ipl_n, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule